// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit works out where a 32-bit core with word-aligned instructions fetches next. It takes one instruction at a time and reads four things with it: the address of that instruction, the decoded word, one register operand and the compare flag. It also takes the saved exception PC. One clock later it reports the next PC and whether control left the sequential path. When the instruction writes the link register, it also reports the index and value to write.

There are two conditional branches, each keyed to one sense of the single compare flag. There is a PC-relative jump and a PC-relative jump-and-link. There are register-indirect jump forms with and without a link. A return-from-exception resumes at the saved exception PC. Relative offsets are measured from the branch instruction's own address. If a taken target is not word aligned, the unit passes it on unchanged and raises a fault flag, so the core can raise its own exception.

Top module: `branch_npc`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no request, `out_valid`, `link_we`, `taken` and `misalign` are all 0.
- R2: A request accepted with `in_valid`=1 on one rising edge produces exactly one result with `out_valid`=1 right after that edge. A cycle with `in_valid`=0 produces `out_valid`=0 after the following edge.
- R3: When no transfer is taken, or the opcode in `instr[31:26]` is none of 0x00, 0x01, 0x03, 0x04, 0x09, 0x11 or 0x12, `next_pc` = `pc` + 4 and `taken` = 0.
- R4: The relative target is `pc` plus `instr[25:0]` shifted left by two and sign-extended from bit 27 to 32 bits. It is measured from the branch's own address, not from `pc` + 4.
- R5: Opcode 0x04 is taken exactly when `flag`=1, and opcode 0x03 exactly when `flag`=0. Both use the relative target, and `taken` reports the outcome.
- R6: Opcode 0x00 always jumps to the relative target. Opcode 0x01 does the same and also writes the link register.
- R7: Opcode 0x11 always jumps to `rb_val`. Opcode 0x12 does the same and also writes the link register.
- R8: Opcode 0x09 always jumps to `epc`, with `taken`=1, whatever the flag.
- R9: `link_we` is 1 only in the result cycle of opcode 0x01 or 0x12. In that cycle `link_data` = `pc` + 4 of that instruction and `link_idx` = 9. Back-to-back linking instructions give one pulse per instruction.
- R10: When a taken target has bits [1:0] other than 00, `misalign`=1 and `next_pc` carries the target unchanged. `link_we` stays 0 for that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is presented this cycle |
| pc | input | 32 | Address of the presented instruction |
| instr | input | 32 | Instruction word |
| rb_val | input | 32 | Value of the register selected by instr[15:11] |
| flag | input | 1 | Compare flag |
| epc | input | 32 | Saved exception PC |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | Control left the sequential path |
| link_we | output | 1 | Write the link register this cycle |
| link_idx | output | 5 | Link register index (9) |
| link_data | output | 32 | Return address to write |
| misalign | output | 1 | Taken target is not word aligned |

## Verification
The embedded properties check the framing on every cycle. Every request yields a result one cycle later, and no result appears without a request. A sequential result always equals the instruction address plus four. A link write always carries that same return address, and never coincides with a misaligned or not-taken result. Only the bench scenarios show that each opcode picks the right target. These cover relative targets measured from the branch address, including the largest negative offset, and the two flag senses. They also cover the indirect and exception-return targets, and link suppression on a faulting indirect jump.

// File: rtl/branch_npc.sv
module branch_npc #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter logic [RIDX_W-1:0] LINK_REG = 5'd9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   rb_val,
  input  logic              flag,
  input  logic [XLEN-1:0]   epc,
  output logic              out_valid,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_data,
  output logic              misalign
);
  localparam int OFF_W = 26;
  localparam logic [5:0] OP_J    = 6'h00;
  localparam logic [5:0] OP_JAL  = 6'h01;
  localparam logic [5:0] OP_BNF  = 6'h03;
  localparam logic [5:0] OP_BF   = 6'h04;
  localparam logic [5:0] OP_RFE  = 6'h09;
  localparam logic [5:0] OP_JR   = 6'h11;
  localparam logic [5:0] OP_JALR = 6'h12;

  wire [5:0]      op      = instr[31:26];
  wire [XLEN-1:0] rel_off = {{(XLEN-OFF_W-2){instr[OFF_W-1]}}, instr[OFF_W-1:0], 2'b00};
  wire [XLEN-1:0] rel_tgt = pc + rel_off;
  wire [XLEN-1:0] seq_pc  = pc + XLEN'(4);

  logic [XLEN-1:0] tgt;
  logic            tk, lnk;

  always_comb begin
    tgt = rel_tgt;
    tk  = 1'b0;
    lnk = 1'b0;
    case (op)
      OP_BF:   tk = flag;
      OP_BNF:  tk = ~flag;
      OP_J:    tk = 1'b1;
      OP_JAL:  begin tk = 1'b1; lnk = 1'b1; end
      OP_JR:   begin tk = 1'b1; tgt = rb_val; end
      OP_JALR: begin tk = 1'b1; tgt = rb_val; lnk = 1'b1; end
      OP_RFE:  begin tk = 1'b1; tgt = epc; end
      default: ;
    endcase
  end

  wire bad = tk & |tgt[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      link_we   <= 1'b0;
      misalign  <= 1'b0;
      next_pc   <= '0;
      link_data <= '0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid & tk;
      link_we   <= in_valid & lnk & ~bad;
      misalign  <= in_valid & bad;
      if (in_valid) begin
        next_pc   <= tk ? tgt : seq_pc;
        link_data <= seq_pc;
      end
    end
  end

  assign link_idx = LINK_REG;

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_fallthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (taken || next_pc == $past(pc) + XLEN'(4)));
  assert_link_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!link_we || link_data == $past(pc) + XLEN'(4)));
  assert_link_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (out_valid && taken && !misalign));
  assert_misalign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (out_valid && taken && next_pc[1:0] != 2'b00));
endmodule

// File: tb/test_branch_npc.sv
module test_branch_npc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] pc = '0, instr = '0, rb_val = '0, epc = '0;
  logic        flag = 1'b0;
  logic        out_valid, taken, link_we, misalign;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [31:0] ldata;
    logic        mis;
  } exp_t;

  exp_t  q[$];
  string tags[$];

  always #2 clk = ~clk;

  branch_npc i_branch_npc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .instr(instr),
    .rb_val(rb_val), .flag(flag), .epc(epc), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .misalign(misalign)
  );

  function automatic exp_t model(logic [31:0] p, logic [31:0] w, logic [31:0] rb,
                                 logic f, logic [31:0] e);
    exp_t r;
    logic [31:0] rel;
    logic [31:0] dst;
    logic jump, lk;
    rel  = p + {{4{w[25]}}, w[25:0], 2'b00};
    dst  = rel;
    jump = 0;
    lk   = 0;
    if (w[31:26] == 6'h04) jump = f;
    else if (w[31:26] == 6'h03) jump = !f;
    else if (w[31:26] == 6'h00) jump = 1;
    else if (w[31:26] == 6'h01) begin jump = 1; lk = 1; end
    else if (w[31:26] == 6'h11) begin jump = 1; dst = rb; end
    else if (w[31:26] == 6'h12) begin jump = 1; dst = rb; lk = 1; end
    else if (w[31:26] == 6'h09) begin jump = 1; dst = e; end
    r.tk    = jump;
    r.npc   = jump ? dst : p + 32'd4;
    r.mis   = jump && (dst[1:0] != 2'b00);
    r.lwe   = lk && !r.mis;
    r.ldata = p + 32'd4;
    return r;
  endfunction

  task automatic issue(logic [31:0] p, logic [31:0] w, logic [31:0] rb,
                       logic f, logic [31:0] e, string tag);
    @(negedge clk);
    pc = p; instr = w; rb_val = rb; flag = f; epc = e; in_valid = 1'b1;
    q.push_back(model(p, w, rb, f, e));
    tags.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [31:0] rel(logic [5:0] op, logic [25:0] off);
    return {op, off};
  endfunction

  function automatic logic [31:0] rj(logic [5:0] op, logic [4:0] rb);
    return {op, 10'b0, rb, 11'b0};
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t  e;
      string t;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: result with no request, out_valid=%0b expected 0", out_valid);
      end else begin
        e = q.pop_front();
        t = tags.pop_front();
        if (next_pc !== e.npc || taken !== e.tk || link_we !== e.lwe ||
            misalign !== e.mis || (e.lwe && (link_data !== e.ldata || link_idx !== 5'd9))) begin
          errors++;
          $display("FAIL %s: npc=%h tk=%0b lwe=%0b ldata=%h idx=%0d mis=%0b expected npc=%h tk=%0b lwe=%0b ldata=%h idx=9 mis=%0b",
                   t, next_pc, taken, link_we, link_data, link_idx, misalign,
                   e.npc, e.tk, e.lwe, e.ldata, e.mis);
        end
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run hung, done=%0b expected 1", done);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || link_we !== 0 || taken !== 0 || misalign !== 0) begin
      errors++;
      $display("FAIL R1: in reset v=%0b lwe=%0b tk=%0b mis=%0b expected all 0",
               out_valid, link_we, taken, misalign);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (out_valid !== 0 || link_we !== 0 || misalign !== 0) begin
      errors++;
      $display("FAIL R1: after reset v=%0b lwe=%0b mis=%0b expected 0", out_valid, link_we, misalign);
    end

    issue(32'h0000_1000, {6'h15, 26'h0}, 0, 1, 0, "R3 other opcode");
    issue(32'h0000_2000, rel(6'h04, 26'h3FF_FFFC), 0, 1, 0, "R5/R4 flag-set branch taken back");
    issue(32'h0000_2000, rel(6'h04, 26'h3FF_FFFC), 0, 0, 0, "R5/R3 flag-set branch not taken");
    issue(32'h0000_3000, rel(6'h03, 26'h10), 0, 0, 0, "R5 flag-clear branch taken");
    issue(32'h0000_3000, rel(6'h03, 26'h10), 0, 1, 0, "R5/R3 flag-clear branch not taken");
    issue(32'h0000_4000, rel(6'h00, 26'h100), 0, 0, 0, "R6/R4 jump from own address");
    issue(32'h8000_0000, rel(6'h00, 26'h200_0000), 0, 1, 0, "R4 largest negative offset");
    issue(32'h0000_5000, rel(6'h01, 26'h2), 0, 0, 0, "R6/R9 jump and link");
    idle(2);
    checks++;
    if (out_valid !== 0 || link_we !== 0) begin
      errors++;
      $display("FAIL R2: idle v=%0b lwe=%0b expected 0", out_valid, link_we);
    end
    issue(32'h0000_7000, rj(6'h11, 5'd3), 32'h0001_2340, 0, 0, "R7 register jump");
    issue(32'h0000_7000, rj(6'h12, 5'd4), 32'h0000_6000, 1, 0, "R7/R9 register jump and link");
    issue(32'h0000_7100, rj(6'h11, 5'd5), 32'h0000_6002, 0, 0, "R10 misaligned register jump");
    issue(32'h0000_7200, rj(6'h12, 5'd6), 32'h0000_6001, 0, 0, "R10 misaligned link suppressed");
    issue(32'h0000_7300, {6'h09, 26'h0}, 0, 0, 32'h0000_9ABC, "R8 exception return");
    issue(32'h0000_7400, {6'h09, 26'h0}, 0, 1, 32'h0000_9ABE, "R8/R10 misaligned exception return");
    issue(32'h0000_A000, rel(6'h01, 26'h1), 0, 0, 0, "R9 back-to-back link first");
    issue(32'h0000_B000, rel(6'h01, 26'h3FF_FFFF), 0, 0, 0, "R9 back-to-back link second");
    issue(32'h0000_C000, rel(6'h04, 26'h8), 0, 1, 0, "R5 taken after link");
    idle(4);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d results missing, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule